// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Macrocells

This block is a two-level configurable logic array. A product stage forms up to sixteen AND terms. Each term may take every one of the eight inputs in true form, in complemented form, or not at all. A sum stage then ORs a chosen set of those terms into each of four outputs. The sum stage can instead run in a fixed grouping mode. In that mode each output ORs its own contiguous block of terms, and the programmed sum connections are ignored.

Each output passes through a macrocell. The macrocell holds a flip-flop, a select that chooses between the flip-flop and the raw sum, and an enable. A disabled output drives a low valid flag and a data value of 0; it is never left floating.

Configuration goes in through a parallel write port while a load signal is held high. A two-state controller tracks that signal. In state ST_LOAD the macrocell flip-flops hold their value. In state ST_RUN they capture the sums on every clock. The controller moves from ST_LOAD to ST_RUN (transition GO_RUN) one cycle after `cfg_en` is low at a clock edge. It moves from ST_RUN to ST_LOAD (transition GO_LOAD) one cycle after `cfg_en` is high at a clock edge. In all other cases it stays in its current state (HOLD_LOAD, HOLD_RUN).

Top module: `pla_array`

## Requirements
- R1: Product row p is set by writing address p (0..15). Data bit i (0..7) enables input i in true form, and data bit 8+i enables input i in complemented form. A term is the AND of its enabled literals, and an input with neither bit set is left out of the term.
- R2: A product row with no literal bit set evaluates to 1. A row with both the true and the complement bit set for some input always evaluates to 0.
- R3: In programmable mode, output j is the OR of the terms whose bits are set in the sum mask at address 16+j, with bit p selecting term p. An all-zero mask gives 0.
- R4: When control bit 8 is 1 (fixed grouping mode), output j is the OR of terms 4j..4j+3, and the sum masks have no effect.
- R5: Control bit j (0..3) selects the registered value for output j when it is 1 and the combinational sum when it is 0. The registered value is the sum captured at a rising edge in ST_RUN. It appears after that edge and not before it.
- R6: Control bit 4+j enables output j. When the bit is 0, `dvalid[j]` is 0 and `dout[j]` is 0. When it is 1, `dvalid[j]` is 1.
- R7: The control word lives at address 20. A write to any address takes effect at a rising edge only when `cfg_en` and `cfg_we` are both 1. A write with `cfg_en` low changes nothing.
- R8: The controller is in ST_LOAD in the cycle after a rising edge that samples `cfg_en` high, and in ST_RUN in the cycle after one that samples it low. Macrocell flip-flops hold their value at any edge taken in ST_LOAD. So after `cfg_en` falls, the first capture happens at the second rising edge.
- R9: Synchronous reset clears every configuration word and every flip-flop and puts the controller in ST_LOAD, so all outputs read 0 with valid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration load enable; also steers the controller |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 5 | Configuration word address |
| cfg_data | input | 16 | Configuration word data |
| din | input | 8 | Array inputs |
| dout | output | 4 | Output values, 0 when disabled |
| dvalid | output | 4 | Per-output driven flag |

## Verification
Outputs set to combinational follow `din` in the same cycle. The bench samples them one nanosecond after driving the inputs, well before the next edge. A configuration write becomes visible after the single rising edge that performs it, so each write is checked at the following falling edge.

Registered outputs change only after the edge that captures them. The bench first checks just before that edge that the old value is still present, and then checks after the edge that the new value has arrived. When `cfg_en` falls, the bench lets the first edge pass with no capture and checks that the value is unchanged. It expects the new value only after the second edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } pla_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_PT   = 16,
    parameter int N_OUT  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_en,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_data,
    output logic [N_PT-1:0][2*N_IN-1:0]      and_rows,
    output logic [N_OUT-1:0][N_PT-1:0]       or_masks,
    output logic [N_OUT-1:0]                 reg_sel,
    output logic [N_OUT-1:0]                 oe,
    output logic                             fixed_or,
    output logic                             run
);

    localparam int OR_BASE   = N_PT;
    localparam int CTRL_ADDR = N_PT + N_OUT;

    pla_state_e state_q, state_d;
    logic       wr;

    assign wr = cfg_en & cfg_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = cfg_en ? ST_LOAD : ST_RUN;
            ST_RUN:  state_d = cfg_en ? ST_LOAD : ST_RUN;
        endcase
    end

    // outputs of the controller
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_LOAD: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
    end

    // configuration words
    always_ff @(posedge clk) begin
        if (rst) begin
            and_rows <= '0;
            or_masks <= '0;
            reg_sel  <= '0;
            oe       <= '0;
            fixed_or <= 1'b0;
        end else if (wr) begin
            for (int p = 0; p < N_PT; p++) begin
                if (cfg_addr == ADDR_W'(p)) and_rows[p] <= cfg_data[2*N_IN-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (cfg_addr == ADDR_W'(OR_BASE + o)) or_masks[o] <= cfg_data[N_PT-1:0];
            end
            if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
                reg_sel  <= cfg_data[N_OUT-1:0];
                oe       <= cfg_data[2*N_OUT-1:N_OUT];
                fixed_or <= cfg_data[2*N_OUT];
            end
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN = 8,
    parameter int N_PT = 16
) (
    input  logic [N_IN-1:0]               din,
    input  logic [N_PT-1:0][2*N_IN-1:0]   rows,
    output logic [N_PT-1:0]               pterm
);

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [N_IN-1:0] use_t, use_c;
        assign use_t    = rows[p][N_IN-1:0];
        assign use_c    = rows[p][2*N_IN-1:N_IN];
        assign pterm[p] = &((~use_t | din) & (~use_c | ~din));
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT  = 16,
    parameter int N_OUT = 4
) (
    input  logic [N_PT-1:0]              pterm,
    input  logic [N_OUT-1:0][N_PT-1:0]   masks,
    input  logic                         fixed_or,
    output logic [N_OUT-1:0]             sum
);

    localparam int GRP = N_PT / N_OUT;
    localparam logic [N_PT-1:0] ONES = '1;

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        localparam logic [N_PT-1:0] FIX_MASK = (ONES >> (N_PT - GRP)) << (o * GRP);
        logic [N_PT-1:0] eff_mask;
        assign eff_mask = fixed_or ? FIX_MASK : masks[o];
        assign sum[o]   = |(pterm & eff_mask);
    end

endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sum,
    input  logic reg_sel,
    input  logic oe,
    output logic dout,
    output logic dvalid
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (run) q <= sum;
    end

    assign dout   = oe & (reg_sel ? q : sum);
    assign dvalid = oe;

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_PT   = 16,
    parameter int N_OUT  = 4,
    parameter int ADDR_W = $clog2(N_PT + N_OUT + 1),
    parameter int DATA_W = max3(2 * N_IN, N_PT, 2 * N_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   din,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  dvalid
);

    logic [N_PT-1:0][2*N_IN-1:0] and_rows;
    logic [N_OUT-1:0][N_PT-1:0]  or_masks;
    logic [N_OUT-1:0]            reg_sel;
    logic [N_OUT-1:0]            oe;
    logic                        fixed_or;
    logic                        run;
    logic [N_PT-1:0]             pterm;
    logic [N_OUT-1:0]            sum;

    pla_cfg_store #(
        .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .and_rows(and_rows), .or_masks(or_masks), .reg_sel(reg_sel),
        .oe(oe), .fixed_or(fixed_or), .run(run)
    );

    pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .din(din), .rows(and_rows), .pterm(pterm)
    );

    pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
        .pterm(pterm), .masks(or_masks), .fixed_or(fixed_or), .sum(sum)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_mc
        pla_macrocell u_mc (
            .clk(clk), .rst(rst), .run(run), .sum(sum[j]),
            .reg_sel(reg_sel[j]), .oe(oe[j]),
            .dout(dout[j]), .dvalid(dvalid[j])
        );
    end

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int N_IN  = 8,
    parameter int N_PT  = 16,
    parameter int N_OUT = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           cfg_en,
    input logic                           cfg_we,
    input logic [N_OUT-1:0]               dout,
    input logic [N_OUT-1:0]               dvalid,
    input logic                           run,
    input logic [N_OUT-1:0]               sum,
    input logic [N_OUT-1:0]               reg_sel,
    input logic [N_OUT-1:0]               oe,
    input logic [N_PT-1:0][2*N_IN-1:0]    and_rows,
    input logic [N_OUT-1:0][N_PT-1:0]     or_masks
);

    // R6
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dout & ~dvalid) == '0);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0) && (dvalid == '0));

    // R7
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_en && cfg_we) |=> $stable(and_rows) && $stable(or_masks)
                                && $stable(oe) && $stable(reg_sel));

    // R8
    enter_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> !run);

    // R8
    enter_run_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> run);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        // R5
        reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (run && oe[j] && reg_sel[j]) ##1 (oe[j] && reg_sel[j])
            |-> dout[j] == $past(sum[j]));

        // R8
        load_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!run && oe[j] && reg_sel[j]) ##1 (oe[j] && reg_sel[j])
            |-> $stable(dout[j]));
    end

endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .dout(dout), .dvalid(dvalid), .run(run), .sum(sum),
    .reg_sel(reg_sel), .oe(oe), .and_rows(and_rows), .or_masks(or_masks)
);

// File: tb/pla_array_test.sv
module pla_array_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [7:0]  din = '0;
    logic [3:0]  dout, dvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pla_array uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .din(din),
        .dout(dout), .dvalid(dvalid)
    );

    // input pattern, expected dout with the base configuration (combinational)
    localparam logic [11:0] VEC [8] = '{
        {8'h00, 4'h1}, {8'h07, 4'h1}, {8'h04, 4'h0}, {8'h0C, 4'h2},
        {8'h1C, 4'h0}, {8'h84, 4'h8}, {8'hFF, 4'h9}, {8'h2B, 4'h3}
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write performed at the rising edge between the two falling edges
    task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_din(input logic [7:0] v);
        @(negedge clk);
        din = v;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R9 reset state
        chk("R9 dout after reset", dout, 4'h0);
        chk("R9 dvalid after reset", dvalid, 4'h0);
        rst = 1'b0;

        // base configuration
        cfg_write(5'd0,  16'h0003);   // a0 & a1
        cfg_write(5'd1,  16'h0400);   // ~a2
        cfg_write(5'd2,  16'h1008);   // a3 & ~a4
        cfg_write(5'd3,  16'h2020);   // a5 & ~a5 -> 0
        cfg_write(5'd4,  16'h0080);   // a7
        cfg_write(5'd16, 16'h0003);
        cfg_write(5'd17, 16'h000C);
        cfg_write(5'd18, 16'h0000);
        cfg_write(5'd19, 16'h0010);
        cfg_write(5'd20, 16'h00F0);   // all enabled, combinational
        @(negedge clk);
        cfg_en = 1'b0;
        chk("R6 dvalid all enabled", dvalid, 4'hF);

        // R1 R2 R3 table walk
        for (int k = 0; k < 8; k++) begin
            set_din(VEC[k][11:4]);
            chk($sformatf("R1 R3 vector %0d", k), dout, VEC[k][3:0]);
        end

        // R5 R8 registered mode; din 0x2B captured at the write edge (RUN)
        cfg_write(5'd20, 16'h00FF);
        chk("R5 registered shows captured", dout, 4'h3);
        set_din(8'h04);
        repeat (2) @(negedge clk);
        chk("R8 hold in ST_LOAD", dout, 4'h3);
        cfg_en = 1'b0;
        @(negedge clk);
        chk("R8 first edge after release no capture", dout, 4'h3);
        @(negedge clk);
        chk("R5 capture at second edge", dout, 4'h0);
        set_din(8'h84);
        chk("R5 not before edge", dout, 4'h0);
        @(negedge clk);
        chk("R5 after edge", dout, 4'h8);

        // R7 ignored write
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd20; cfg_data = 16'h0000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R7 ignored write dvalid", dvalid, 4'hF);
        chk("R7 ignored write dout", dout, 4'h8);

        // R6 output 0 disabled, combinational
        cfg_write(5'd20, 16'h00E0);
        #1;
        chk("R6 dvalid partial", dvalid, 4'hE);
        chk("R6 dout with 0x84", dout, 4'h8);
        set_din(8'h00);
        chk("R6 disabled output reads 0", dout, 4'h0);

        // R2 R3 term with conflicting literals, then empty row
        cfg_write(5'd20, 16'h00F0);
        cfg_write(5'd18, 16'h0008);
        set_din(8'h20);
        chk("R2 conflicting literals give 0", dout, 4'h1);
        cfg_write(5'd18, 16'h0020);
        #1;
        chk("R2 empty row gives 1", dout, 4'h5);

        // R4 fixed grouping mode
        cfg_write(5'd20, 16'h01F0);
        set_din(8'h04);
        chk("R4 fixed groups 0x04", dout, 4'hE);
        set_din(8'h00);
        chk("R4 fixed groups 0x00", dout, 4'hF);

        // R9 reset mid-run
        @(negedge clk);
        cfg_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 dout after mid reset", dout, 4'h0);
        chk("R9 dvalid after mid reset", dvalid, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule